// File: doc/BRIEF.md
# Embedded-Sync Video Timing Analyzer

This block watches an 8-bit 4:2:2 digital video stream that carries its timing inline, one byte per clock. It hunts for the four-byte timing marker (one 0xFF byte, then two 0x00 bytes, then a flag byte). From the flag byte it pulls out the field, vertical-blank and horizontal (start/end of active video) bits. It checks the four protection bits against those flags. A marker whose protection bits are wrong is still used for timing; it only raises a sticky error.

Using the end-of-active markers, the block measures how many clocks one line lasts and how many payload clocks lie between start-of-active and end-of-active. It also counts active and blanking lines over each frame. Line geometry is compared with expected values that the user supplies. Frame geometry is simply reported, so a user can see whether a stream carries, say, 507 or 508 active lines without assuming either. A single pulse input clears all sticky errors.

The marker search is a four-state machine. `S_HUNT` waits for 0xFF. `S_FF` has seen 0xFF. `S_Z1` has seen one 0x00 after it. `S_Z2` has seen the second 0x00, so the current byte is the flag byte. The transitions are as follows:
- `HUNT→FF` on 0xFF.
- `FF→Z1` on 0x00, `FF→FF` on 0xFF, and `FF→HUNT` on any other byte.
- `Z1→Z2` on 0x00, `Z1→FF` on 0xFF, and `Z1→HUNT` on any other byte.
- `Z2→FF` when the flag byte is 0xFF, and `Z2→HUNT` otherwise.

Top module: `vid_timing_probe`

## Requirements
- R1: A marker is recognised only when a flag byte with bit 7 set directly follows 0xFF,0x00,0x00. Extra leading 0xFF bytes are allowed, and any other byte breaks the search. `code_stb` is high for the one cycle after the clock edge that samples the flag byte.
- R2: On each recognised marker, `code_f`, `code_v` and `code_h` take flag-byte bits 6, 5 and 4. They hold those values until the next recognised marker.
- R3: Flag-byte bits [3:0] must equal {V^H, F^H, F^V, F^V^H}. When they do not, `err_prot` is set and stays set. Such a marker still updates the flags and still counts for timing.
- R4: A flag byte after a preamble that has bit 7 clear sets `err_frame` and stays set. It leaves the flags unchanged and produces no `code_stb`.
- R5: `line_clks` is the number of clocks from one end-of-active marker (H=1) flag byte to the next. The value is compared with `exp_line_clks` from the second such marker after reset onward, and a mismatch sets the sticky `err_line`.
- R6: `act_clks` is the number of clocks from a start-of-active (H=0) flag byte to the next end-of-active flag byte, minus 4. It is updated and compared with `exp_act_clks` only when a start-of-active marker came since the previous end-of-active marker. A mismatch sets the sticky `err_act`.
- R7: Each end-of-active marker with V=0 counts one active line, and each with V=1 counts one blanking line. On the first marker with V=0 after a marker with V=1, both counts go to `act_lines`/`blank_lines` and `frame_stb` pulses. The counts then restart, and an end-of-active marker that causes the transition counts as the first active line of the new frame.
- R8: A high `err_clr` clears all four sticky errors at the next edge. An error raised at that same edge wins over the clear.
- R9: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Video stream byte |
| err_clr | input | 1 | Clears sticky errors |
| exp_line_clks | input | CLK_W | Expected clocks per line |
| exp_act_clks | input | CLK_W | Expected active payload clocks |
| code_stb | output | 1 | One-cycle pulse per recognised marker |
| code_f | output | 1 | Field flag of last marker |
| code_v | output | 1 | Vertical-blank flag of last marker |
| code_h | output | 1 | Horizontal flag of last marker (1 = end of active) |
| frame_stb | output | 1 | Pulse when frame line counts are latched |
| line_clks | output | CLK_W | Measured clocks per line |
| act_clks | output | CLK_W | Measured active payload clocks |
| act_lines | output | LINE_W | Active lines in the last frame |
| blank_lines | output | LINE_W | Blanking lines in the last frame |
| err_prot | output | 1 | Sticky protection-bit error |
| err_frame | output | 1 | Sticky malformed flag byte |
| err_line | output | 1 | Sticky line-length mismatch |
| err_act | output | 1 | Sticky active-length mismatch |

## Verification
All eight legal flag bytes are sent, which shows that flag decoding and protection checking agree on every F/V/H combination. Two flag bytes that have the blanking flags but a wrong low nibble tell a protection fault apart from a framing fault, and a flag byte with bit 7 clear shows the opposite case. Padded and broken preambles separate a correct resync from a false match. Short streams of whole lines with known payload lengths, including one lengthened blanking gap and one lengthened active span, show that line and active measurements catch each fault on its own. Two frames with different active/blanking splits show that line counts are measured rather than fixed.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

    typedef enum logic [1:0] {
        S_HUNT,
        S_FF,
        S_Z1,
        S_Z2
    } seek_t;

    localparam logic [7:0] PRE_ONES  = 8'hFF;
    localparam logic [7:0] PRE_ZEROS = 8'h00;
    localparam int         HDR_LEN   = 4;

    function automatic logic [3:0] prot_nib(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vtp_code_seek.sv
module vtp_code_seek
    import vtp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic       code_stb,
    output logic       prot_stb,
    output logic       fbad_stb,
    output logic       code_f,
    output logic       code_v,
    output logic       code_h
);

    seek_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_HUNT: nxt = (din == PRE_ONES) ? S_FF : S_HUNT;
            S_FF:   nxt = (din == PRE_ZEROS) ? S_Z1 : ((din == PRE_ONES) ? S_FF : S_HUNT);
            S_Z1:   nxt = (din == PRE_ZEROS) ? S_Z2 : ((din == PRE_ONES) ? S_FF : S_HUNT);
            S_Z2:   nxt = (din == PRE_ONES) ? S_FF : S_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_stb <= 1'b0;
            prot_stb <= 1'b0;
            fbad_stb <= 1'b0;
            code_f   <= 1'b0;
            code_v   <= 1'b0;
            code_h   <= 1'b0;
        end else begin
            code_stb <= 1'b0;
            prot_stb <= 1'b0;
            fbad_stb <= 1'b0;
            if (state == S_Z2) begin
                if (din[7]) begin
                    code_stb <= 1'b1;
                    code_f   <= din[6];
                    code_v   <= din[5];
                    code_h   <= din[4];
                    prot_stb <= (din[3:0] != prot_nib(din[6], din[5], din[4]));
                end else begin
                    fbad_stb <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vtp_line_meter.sv
module vtp_line_meter
    import vtp_pkg::*;
#(
    parameter int CLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_stb,
    input  logic             code_h,
    input  logic [CLK_W-1:0] exp_line_clks,
    input  logic [CLK_W-1:0] exp_act_clks,
    output logic [CLK_W-1:0] line_clks,
    output logic [CLK_W-1:0] act_clks,
    output logic             line_bad,
    output logic             act_bad
);

    localparam logic [CLK_W-1:0] CMAX = {CLK_W{1'b1}};
    localparam logic [CLK_W-1:0] HDR  = CLK_W'(HDR_LEN);

    logic [CLK_W-1:0] line_cnt, act_cnt, act_val;
    logic             have_prev, sav_seen;
    logic             eav, sav;

    assign eav     = code_stb & code_h;
    assign sav     = code_stb & ~code_h;
    assign act_val = (act_cnt >= HDR) ? (act_cnt - HDR) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt  <= '0;
            act_cnt   <= '0;
            have_prev <= 1'b0;
            sav_seen  <= 1'b0;
            line_clks <= '0;
            act_clks  <= '0;
            line_bad  <= 1'b0;
            act_bad   <= 1'b0;
        end else begin
            line_cnt <= eav ? CLK_W'(1) : ((line_cnt == CMAX) ? CMAX : line_cnt + CLK_W'(1));
            act_cnt  <= sav ? CLK_W'(1) : ((act_cnt == CMAX) ? CMAX : act_cnt + CLK_W'(1));
            line_bad <= 1'b0;
            act_bad  <= 1'b0;
            if (eav) begin
                have_prev <= 1'b1;
                sav_seen  <= 1'b0;
                if (have_prev) begin
                    line_clks <= line_cnt;
                    line_bad  <= (line_cnt != exp_line_clks);
                end
                if (sav_seen) begin
                    act_clks <= act_val;
                    act_bad  <= (act_val != exp_act_clks);
                end
            end
            if (sav) sav_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/vtp_frame_meter.sv
module vtp_frame_meter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_stb,
    input  logic              code_v,
    input  logic              code_h,
    output logic              frame_stb,
    output logic [LINE_W-1:0] act_lines,
    output logic [LINE_W-1:0] blank_lines
);

    localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] act_cnt, blank_cnt;
    logic              prev_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt     <= '0;
            blank_cnt   <= '0;
            prev_v      <= 1'b0;
            frame_stb   <= 1'b0;
            act_lines   <= '0;
            blank_lines <= '0;
        end else begin
            frame_stb <= 1'b0;
            if (code_stb) begin
                prev_v <= code_v;
                if (!code_v && prev_v) begin
                    act_lines   <= act_cnt;
                    blank_lines <= blank_cnt;
                    frame_stb   <= 1'b1;
                    act_cnt     <= code_h ? LINE_W'(1) : '0;
                    blank_cnt   <= '0;
                end else if (code_h) begin
                    if (code_v) blank_cnt <= (blank_cnt == LMAX) ? LMAX : blank_cnt + LINE_W'(1);
                    else        act_cnt   <= (act_cnt == LMAX) ? LMAX : act_cnt + LINE_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vid_timing_probe.sv
module vid_timing_probe #(
    parameter int CLK_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        din,
    input  logic              err_clr,
    input  logic [CLK_W-1:0]  exp_line_clks,
    input  logic [CLK_W-1:0]  exp_act_clks,
    output logic              code_stb,
    output logic              code_f,
    output logic              code_v,
    output logic              code_h,
    output logic              frame_stb,
    output logic [CLK_W-1:0]  line_clks,
    output logic [CLK_W-1:0]  act_clks,
    output logic [LINE_W-1:0] act_lines,
    output logic [LINE_W-1:0] blank_lines,
    output logic              err_prot,
    output logic              err_frame,
    output logic              err_line,
    output logic              err_act
);

    logic prot_stb, fbad_stb, line_bad, act_bad;

    vtp_code_seek u_seek (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .code_stb (code_stb),
        .prot_stb (prot_stb),
        .fbad_stb (fbad_stb),
        .code_f   (code_f),
        .code_v   (code_v),
        .code_h   (code_h)
    );

    vtp_line_meter #(.CLK_W(CLK_W)) u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .code_stb      (code_stb),
        .code_h        (code_h),
        .exp_line_clks (exp_line_clks),
        .exp_act_clks  (exp_act_clks),
        .line_clks     (line_clks),
        .act_clks      (act_clks),
        .line_bad      (line_bad),
        .act_bad       (act_bad)
    );

    vtp_frame_meter #(.LINE_W(LINE_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_stb    (code_stb),
        .code_v      (code_v),
        .code_h      (code_h),
        .frame_stb   (frame_stb),
        .act_lines   (act_lines),
        .blank_lines (blank_lines)
    );

    // sticky error bits: a new error wins over a clear in the same cycle (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_prot  <= 1'b0;
            err_frame <= 1'b0;
            err_line  <= 1'b0;
            err_act   <= 1'b0;
        end else begin
            err_prot  <= (err_prot  & ~err_clr) | prot_stb;
            err_frame <= (err_frame & ~err_clr) | fbad_stb;
            err_line  <= (err_line  & ~err_clr) | line_bad;
            err_act   <= (err_act   & ~err_clr) | act_bad;
        end
    end

endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
    parameter int CLK_W  = 12,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr,
    input logic              code_stb,
    input logic              code_f,
    input logic              code_v,
    input logic              code_h,
    input logic              frame_stb,
    input logic [LINE_W-1:0] act_lines,
    input logic [LINE_W-1:0] blank_lines,
    input logic              err_prot,
    input logic              err_frame,
    input logic              err_line,
    input logic              prot_stb,
    input logic              fbad_stb,
    input logic              line_bad
);

    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_stb, fbad_stb}));

    p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !code_stb |-> $stable({code_f, code_v, code_h}));

    p_prot_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_prot) |-> $past(prot_stb));

    p_frame_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> $past(fbad_stb));

    p_geom_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> $stable({act_lines, blank_lines}));

    p_latch_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> ($past(code_stb) && !$past(code_v)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !line_bad) |=> !err_line);

endmodule

bind vid_timing_probe vtp_checker #(.CLK_W(CLK_W), .LINE_W(LINE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_clr     (err_clr),
    .code_stb    (code_stb),
    .code_f      (code_f),
    .code_v      (code_v),
    .code_h      (code_h),
    .frame_stb   (frame_stb),
    .act_lines   (act_lines),
    .blank_lines (blank_lines),
    .err_prot    (err_prot),
    .err_frame   (err_frame),
    .err_line    (err_line),
    .prot_stb    (prot_stb),
    .fbad_stb    (fbad_stb),
    .line_bad    (line_bad)
);

// File: tb/vid_timing_probe_tb.sv
`timescale 1ns/1ps
module vid_timing_probe_tb_top;

    localparam int CLK_W  = 12;
    localparam int LINE_W = 10;
    localparam int ACT_B  = 16;
    localparam int BLK_B  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        din = 8'h10;
    logic              err_clr = 1'b0;
    logic [CLK_W-1:0]  exp_line_clks = CLK_W'(ACT_B + BLK_B + 8);
    logic [CLK_W-1:0]  exp_act_clks  = CLK_W'(ACT_B);
    logic              code_stb, code_f, code_v, code_h, frame_stb;
    logic [CLK_W-1:0]  line_clks, act_clks;
    logic [LINE_W-1:0] act_lines, blank_lines;
    logic              err_prot, err_frame, err_line, err_act;

    int total = 0;
    int bad = 0;
    int n_codes = 0;
    int n_frames = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vid_timing_probe #(.CLK_W(CLK_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .err_clr(err_clr),
        .exp_line_clks(exp_line_clks), .exp_act_clks(exp_act_clks),
        .code_stb(code_stb), .code_f(code_f), .code_v(code_v), .code_h(code_h),
        .frame_stb(frame_stb), .line_clks(line_clks), .act_clks(act_clks),
        .act_lines(act_lines), .blank_lines(blank_lines),
        .err_prot(err_prot), .err_frame(err_frame), .err_line(err_line), .err_act(err_act)
    );

    always @(posedge clk) begin
        if (rst_n && code_stb)  n_codes++;
        if (rst_n && frame_stb) n_frames++;
    end

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic chk(input string req, input int actual, input int expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic clr = 1'b0);
        @(negedge clk);
        din = b;
        err_clr = clr;
    endtask

    task automatic send_pre();
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00);
    endtask

    task automatic send_code_pad(input logic [7:0] code);
        send_pre(); send_byte(code); send_byte(8'h10); send_byte(8'h10);
    endtask

    task automatic send_line(input logic v, input int act_b, input int blk_b, input logic clr = 1'b0);
        send_pre(); send_byte(xy(1'b0, v, 1'b1));
        for (int i = 0; i < blk_b; i++) send_byte(8'h10);
        send_pre(); send_byte(xy(1'b0, v, 1'b0));
        for (int i = 0; i < act_b; i++) send_byte(8'h20, (i == act_b - 1) ? clr : 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; din = 8'h10; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_codes = 0; n_frames = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R9 code_stb", code_stb, 0);
        chk("R9 flags", {code_f, code_v, code_h}, 0);
        chk("R9 line_clks", line_clks, 0);
        chk("R9 act_lines", act_lines, 0);
        chk("R9 errors", {err_prot, err_frame, err_line, err_act}, 0);
    endtask

    task automatic t_all_codes();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            send_code_pad(xy(i[2], i[1], i[0]));
            chk("R2 flags", {code_f, code_v, code_h}, i);
            chk("R1 code count", n_codes, i + 1);
            chk("R3 good code no error", err_prot, 0);
        end
    endtask

    task automatic t_bad_prot();
        do_reset();
        send_code_pad(8'hAE);
        chk("R3 flags kept on bad nibble", {code_f, code_v, code_h}, 3'b010);
        chk("R3 err_prot set", err_prot, 1);
        chk("R3 bad code still counted", n_codes, 1);
        send_byte(8'h10, 1'b1); send_byte(8'h10); send_byte(8'h10);
        chk("R8 clear err_prot", err_prot, 0);
        send_pre(); send_byte(8'hB3);
        send_byte(8'h10, 1'b1); send_byte(8'h10); send_byte(8'h10);
        chk("R8 set wins over clear", err_prot, 1);
        chk("R3 flags of 0xB3", {code_f, code_v, code_h}, 3'b011);
    endtask

    task automatic t_framing();
        do_reset();
        send_code_pad(xy(1'b1, 1'b0, 1'b1));
        send_code_pad(8'h55);
        chk("R4 err_frame set", err_frame, 1);
        chk("R4 flags unchanged", {code_f, code_v, code_h}, 3'b101);
        chk("R4 no strobe", n_codes, 1);
        chk("R4 no prot error", err_prot, 0);
        send_byte(8'h10, 1'b1); send_byte(8'h10); send_byte(8'h10);
        chk("R8 clear err_frame", err_frame, 0);
    endtask

    task automatic t_resync();
        do_reset();
        send_byte(8'hFF); send_byte(8'hFF);
        send_code_pad(8'h9D);
        chk("R1 padded preamble found", n_codes, 1);
        chk("R1 padded preamble flags", {code_f, code_v, code_h}, 3'b001);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h10);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'hC7);
        send_byte(8'h10); send_byte(8'h10);
        chk("R1 broken preamble ignored", n_codes, 1);
        chk("R1 broken preamble flags", {code_f, code_v, code_h}, 3'b001);
    endtask

    task automatic t_geometry_a();
        do_reset();
        for (int i = 0; i < 2; i++) send_line(1'b1, ACT_B, BLK_B);
        for (int i = 0; i < 5; i++) send_line(1'b0, ACT_B, BLK_B);
        for (int i = 0; i < 3; i++) send_line(1'b1, ACT_B, BLK_B);
        send_line(1'b0, ACT_B, BLK_B);
        chk("R7 act_lines", act_lines, 5);
        chk("R7 blank_lines", blank_lines, 3);
        chk("R7 frame strobes", n_frames, 2);
        chk("R5 line_clks", line_clks, ACT_B + BLK_B + 8);
        chk("R6 act_clks", act_clks, ACT_B);
        chk("R5 R6 no length errors", {err_line, err_act}, 0);
        send_line(1'b0, ACT_B, BLK_B + 4);
        send_line(1'b0, ACT_B, BLK_B);
        chk("R5 long line measured", line_clks, ACT_B + BLK_B + 12);
        chk("R5 err_line set", err_line, 1);
        chk("R6 act unaffected", err_act, 0);
        send_line(1'b0, ACT_B + 4, BLK_B - 4, 1'b1);
        send_line(1'b0, ACT_B, BLK_B);
        chk("R8 err_line cleared", err_line, 0);
        chk("R6 long active measured", act_clks, ACT_B + 4);
        chk("R6 err_act set", err_act, 1);
        chk("R5 line length still right", line_clks, ACT_B + BLK_B + 8);
    endtask

    task automatic t_geometry_b();
        do_reset();
        send_line(1'b1, ACT_B, BLK_B);
        for (int i = 0; i < 7; i++) send_line(1'b0, ACT_B, BLK_B);
        for (int i = 0; i < 2; i++) send_line(1'b1, ACT_B, BLK_B);
        send_line(1'b0, ACT_B, BLK_B);
        chk("R7 second split act_lines", act_lines, 7);
        chk("R7 second split blank_lines", blank_lines, 2);
    endtask

    initial begin
        t_reset_state();
        t_all_codes();
        t_bad_prot();
        t_framing();
        t_resync();
        t_geometry_a();
        t_geometry_b();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule